// File: doc/BRIEF.md
# GPIO Port Edge Interrupt Controller

This block monitors a port of general-purpose input pins and raises a single level interrupt for the whole port when any pin shows the edge selected for it. Each pin has its own trigger selection: off, low-to-high, high-to-low, or both directions. Raw pin levels pass through a two-stage synchroniser. Edges are then found by comparing the synchronised level with a registered copy from the previous cycle.

Every detected edge sets a sticky per-pin flag. The interrupt output is the OR of all flags. Firmware reads the flag register over a small register port to learn which pins fired, and that read clears the flags. An edge that lands in the same cycle as the clearing read is kept. A second register at the same port holds the per-pin trigger codes and can be written and read back.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset the trigger register reads zero, the flag register reads zero and `irq` is low.
- R2: A write with `reg_addr`=0 stores `reg_wdata` in the trigger register. Bits [2i+1:2i] hold the code for pin i: 00 off, 01 low-to-high, 10 high-to-low, 11 both. A read with `reg_addr`=0 returns the stored value.
- R3: A pin with code 01 sets its flag on a 0-to-1 change and not on a 1-to-0 change.
- R4: A pin with code 10 sets its flag on a 1-to-0 change and not on a 0-to-1 change.
- R5: A pin with code 11 sets its flag on a change in either direction.
- R6: A pin with code 00 never sets its flag.
- R7: A flag becomes visible on the third rising clock edge after the pin input changes, and not before.
- R8: `irq` is high whenever any flag is set. It stays high with no read.
- R9: With `reg_addr`=1, `reg_rdata` shows the flags in bits [PINS-1:0] and zeros above them. Asserting `reg_rd` at that address clears all flags at the next clock edge. A read at address 0 leaves the flags unchanged.
- R10: An edge that would set a flag in the same cycle as a clearing read leaves that flag set after the read.
- R11: Writing code 00 for a pin whose flag is already set leaves the flag set.
- R12: Edges on several pins in the same cycle set each of their flags together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| pin_in | input | PINS | Raw, asynchronous pin levels |
| reg_addr | input | 1 | Register select: 0 trigger codes, 1 flags |
| reg_wr | input | 1 | Write strobe, affects the trigger register only |
| reg_rd | input | 1 | Read strobe; at address 1 it clears the flags |
| reg_wdata | input | 2*PINS | Write data |
| reg_rdata | output | 2*PINS | Combinational read data for `reg_addr` |
| irq | output | 1 | Port interrupt request, level |

## Verification
The bench sweeps every trigger code against both edge directions on every pin. The other pins are given unrelated codes but kept still, so a set flag can be traced to one pin and one code, and each code is told apart by the directions it accepts. Edges on many pins at once separate per-pin latching from a shared bit. The flag register is sampled one cycle before and on the cycle of the expected latch, which pins down the synchroniser depth. Separate cases place an edge on the cycle of a clearing read, read the trigger register while flags are set, and switch a pin to off after its flag is set. These show whether a clear can discard a new event and whether anything other than a flag read clears a flag.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_BOTH = 2'b11
  } trig_e;

  localparam logic SEL_TRIG = 1'b0;
  localparam logic SEL_FLAG = 1'b1;

  // Decide whether a level change from was_lvl to now_lvl matches mode.
  function automatic logic trig_match(input trig_e mode, input logic was_lvl,
                                      input logic now_lvl);
    logic up;
    logic dn;
    up = !was_lvl && now_lvl;
    dn = was_lvl && !now_lvl;
    case (mode)
      TRIG_RISE: return up;
      TRIG_FALL: return dn;
      TRIG_BOTH: return up | dn;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= raw;
      stab_q <= meta_q;
    end
  end

  assign synced = stab_q;
endmodule

// File: rtl/gpio_edge_find.sv
module gpio_edge_find
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] lvl,
  input  logic [2*PINS-1:0] trig_cfg,
  output logic [PINS-1:0] evt
);
  logic [PINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    assign evt[i] = trig_match(trig_e'(trig_cfg[2*i +: 2]), prev_q[i], lvl[i]);

    // An event for an off pin must never appear.
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_cfg[2*i +: 2] == 2'b00) |-> !evt[i]) else $error("off pin fired"); // R6
  end

  // An event only happens where the level actually moved.
  AST_EVENT_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~(lvl ^ prev_q)) == '0) else $error("event without change"); // R3
endmodule

// File: rtl/gpio_flag_store.sv
module gpio_flag_store #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] evt,
  input  logic            clr,
  output logic [PINS-1:0] flags,
  output logic            irq
);
  logic [PINS-1:0] flag_q;
  logic [PINS-1:0] flag_d;

  always_comb begin
    flag_d = clr ? '0 : flag_q;
    flag_d = flag_d | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags = flag_q;
  assign irq   = |flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flag_q & $past(flag_q)) == $past(flag_q))) else $error("flag dropped"); // R11
  AST_SET_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(evt)) == '0)) else $error("flag from nowhere"); // R7
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((flag_q & ~$past(evt)) == '0)) else $error("clear failed"); // R9
  AST_KEEP_COINCIDENT: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((flag_q & $past(evt)) == $past(evt))) else $error("event lost"); // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(evt) != '0)) else $error("irq without event"); // R8
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 8,
  localparam int DATA_W = 2 * PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   pin_in,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [DATA_W-1:0] trig_q;
  logic [PINS-1:0]   lvl_sync;
  logic [PINS-1:0]   edge_evt;
  logic [PINS-1:0]   flag_vec;
  logic              flag_clr;
  logic              trig_we;

  assign trig_we  = reg_wr && (reg_addr == SEL_TRIG);
  assign flag_clr = reg_rd && (reg_addr == SEL_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       trig_q <= '0;
    else if (trig_we) trig_q <= reg_wdata;
  end

  gpio_pin_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .synced(lvl_sync)
  );

  gpio_edge_find #(.PINS(PINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .trig_cfg(trig_q), .evt(edge_evt)
  );

  gpio_flag_store #(.PINS(PINS)) u_flag (
    .clk(clk), .rst_n(rst_n), .evt(edge_evt), .clr(flag_clr),
    .flags(flag_vec), .irq(irq)
  );

  always_comb begin
    if (reg_addr == SEL_TRIG) reg_rdata = trig_q;
    else                      reg_rdata = {{(DATA_W-PINS){1'b0}}, flag_vec};
  end

  AST_TRIG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_we |=> (trig_q == $past(reg_wdata))) else $error("trigger write lost"); // R2
  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_we |=> $stable(trig_q)) else $error("trigger changed"); // R2
endmodule

// File: tb/sim_gpio_edge_irq.sv
module sim_gpio_edge_irq;
  localparam int PINS = 8;
  localparam int DW = 2 * PINS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PINS-1:0] pin_in = '0;
  logic          reg_addr = 1'b0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  gpio_edge_irq #(.PINS(PINS)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_trig(input logic [DW-1:0] v);
    reg_addr = 1'b0; reg_wdata = v; reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic a, output logic [DW-1:0] v);
    reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic rd_clear(output logic [DW-1:0] v);
    reg_addr = 1'b1; reg_rd = 1'b1; #1 v = reg_rdata;
    step(1);
    reg_rd = 1'b0;
  endtask

  // Put pins at a level with every pin off, then empty the flags.
  task automatic settle(input logic [PINS-1:0] lvl);
    logic [DW-1:0] d;
    wr_trig('0);
    pin_in = lvl;
    step(4);
    rd_clear(d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    logic [DW-1:0] cfg;
    logic [PINS-1:0] expm;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    peek(1'b0, v); chk(v, 0, "R1 trig reset");
    peek(1'b1, v); chk(v, 0, "R1 flag reset");
    chk(irq, 0, "R1 irq reset");

    // R2 write and read back
    wr_trig(16'hB1E4);
    peek(1'b0, v); chk(v, 16'hB1E4, "R2 trig readback");

    // Sweep: R3 R4 R5 R6 R7 R9 over every code, direction and pin
    for (int m = 0; m < 4; m++) begin
      for (int dir = 0; dir < 2; dir++) begin
        for (int p = 0; p < PINS; p++) begin
          settle(dir == 0 ? '0 : '1);
          cfg = '0;
          for (int q = 0; q < PINS; q++)
            cfg[2*q +: 2] = (q == p) ? 2'(m) : 2'((q * 3 + m) % 4);
          wr_trig(cfg);
          pin_in[p] = ~pin_in[p];
          expm = '0;
          // code bit0 accepts 0->1 (dir 0), bit1 accepts 1->0 (dir 1)
          if (((m & 1) != 0 && dir == 0) || ((m & 2) != 0 && dir == 1)) expm[p] = 1'b1;
          step(2);
          peek(1'b1, v); chk(v, 0, "R7 not before third edge");
          step(1);
          peek(1'b1, v);
          chk(v, {8'h00, expm}, m == 0 ? "R6 off code" :
                                m == 1 ? "R3 rise code" :
                                m == 2 ? "R4 fall code" : "R5 both code");
          chk(irq, |expm, "R8 irq follows flags");
          rd_clear(v); chk(v, {8'h00, expm}, "R9 read returns flags");
          peek(1'b1, v); chk(v, 0, "R9 flags cleared");
          chk(irq, 0, "R9 irq cleared");
        end
      end
    end

    // R12 several pins together, R8 irq holds
    settle('0);
    wr_trig('1);
    pin_in = 8'hA5;
    step(3);
    peek(1'b1, v); chk(v, 16'h00A5, "R12 multi pin flags");
    step(5);
    chk(irq, 1, "R8 irq holds without read");
    // R9 a read of the trigger register leaves flags
    reg_addr = 1'b0; reg_rd = 1'b1; step(1); reg_rd = 1'b0;
    peek(1'b1, v); chk(v, 16'h00A5, "R9 trig read keeps flags");

    // R11 switching off keeps a set flag
    settle('0);
    wr_trig(16'h0010);
    pin_in[2] = 1'b1;
    step(3);
    wr_trig('0);
    step(2);
    peek(1'b1, v); chk(v, 16'h0004, "R11 off keeps flag");
    chk(irq, 1, "R11 irq kept");

    // R10 edge coincident with clearing read
    settle('0);
    wr_trig(16'h0005);
    pin_in[0] = 1'b1;
    step(3);
    pin_in[1] = 1'b1;
    step(2);
    rd_clear(v); chk(v, 16'h0001, "R10 read value");
    peek(1'b1, v); chk(v, 16'h0002, "R10 coincident event kept");
    chk(irq, 1, "R10 irq after coincident");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule